// File: doc/BRIEF.md
# Multiplexed Bus Splitter and Device Select Decoder

This block sits between a processor with a shared address/data bus and a conventional system bus. The processor puts the low address byte on the shared lines while an address strobe is high, and moves on to data afterwards. The block captures that byte and holds it until the next strobe. It joins the byte with the high address byte, which is never shared, to form a full address.

The same stage decodes the processor's read strobe, write strobe and I/O-versus-memory status line into four separate active-low command strobes: memory read, memory write, I/O read and I/O write. It also produces active-low selects for a ROM window, a RAM window and a bank of I/O ports.

Every memory select is qualified by a memory cycle and every port select by an I/O cycle. Port selects are decoded from the high address byte alone, because an I/O instruction copies the port number onto it. All outputs are registered and appear one clock after the inputs that cause them.

Top module: `bus_split_decoder`

## Requirements
- R1: While `addr_strobe` is 1 the low address register loads `ad_lo`; while it is 0 the register holds. `sys_addr[7:0]` shows this register one clock after the sampling edge.
- R2: `sys_addr[15:8]` equals `a_hi` from the previous clock edge, whatever the value of `addr_strobe`.
- R3: When exactly one of `rd_n`/`wr_n` is low, exactly one command strobe goes low one clock later. That strobe is `mem_rd_n`, `mem_wr_n`, `io_rd_n` or `io_wr_n`, chosen by the strobe (read or write) and by `io_not_mem` (0 = memory, 1 = I/O).
- R4: When `rd_n` and `wr_n` are both low, `bus_err` is 1 one clock later, and no command strobe and no select is asserted. In every other case `bus_err` is 0.
- R5: When `rd_n` and `wr_n` are both high, every command strobe and every select is high one clock later.
- R6: `rom_sel_n` is low one clock after a memory read or write whose address (high byte, and low byte from the register as loaded at that edge) lies in 0x0000–0x3FFF.
- R7: `ram_sel_n` is low one clock after a memory read or write whose address lies in 0x4000–0x5FFF.
- R8: A memory cycle at or above 0x6000 asserts no memory select, and no I/O cycle ever asserts `rom_sel_n` or `ram_sel_n`.
- R9: During an I/O read or write, `port_sel_n[k]` is low one clock later, where k = `a_hi[7:5]`. All other port selects stay high, and the low address byte has no effect on the choice. No port select is asserted in a memory cycle.
- R10: While `rst` is 1, every strobe and select is high on the next edge, `bus_err` is 0, and `sys_addr` and the low address register are 0, whatever the other inputs are.
- R11: `rom_sel_n` and `ram_sel_n` are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_strobe | input | 1 | High while the shared lines carry the low address byte |
| ad_lo | input | 8 | Shared low address / data lines |
| a_hi | input | 8 | High address byte (unshared) |
| rd_n | input | 1 | Processor read strobe, active low |
| wr_n | input | 1 | Processor write strobe, active low |
| io_not_mem | input | 1 | Cycle type: 1 = I/O, 0 = memory |
| sys_addr | output | 16 | Demultiplexed full address |
| mem_rd_n | output | 1 | Memory read command, active low |
| mem_wr_n | output | 1 | Memory write command, active low |
| io_rd_n | output | 1 | I/O read command, active low |
| io_wr_n | output | 1 | I/O write command, active low |
| rom_sel_n | output | 1 | ROM window select, active low |
| ram_sel_n | output | 1 | RAM window select, active low |
| port_sel_n | output | 8 | Port selects, one per value of a_hi[7:5], active low |
| bus_err | output | 1 | Read and write asserted together |

## Verification
The bench uses the default parameters: a 16-bit address, a ROM window at 0 of 16 KB, a RAM window directly above it of 8 KB, and three port bits giving eight port selects. With these values both window edges (0x3FFF/0x4000 and 0x5FFF/0x6000) and the top of the map fall at addresses the stimulus hits on purpose. Random I/O cycles reach all eight port selects, with low bytes that differ from the port number. Thousands of random cycles also mix memory and I/O accesses, conflicting strobes and strobe pulses in the middle of a cycle against a reference model that runs every clock.

// File: rtl/bsd_pkg.sv
package bsd_pkg;

  typedef struct packed {
    logic mem_rd;
    logic mem_wr;
    logic io_rd;
    logic io_wr;
  } bsd_cmd_t;

  localparam int unsigned CMD_W = 4;

endpackage

// File: rtl/bsd_addr_latch.sv
module bsd_addr_latch #(
  parameter int unsigned LO_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [LO_W-1:0] d,
  output logic [LO_W-1:0] next_val,
  output logic [LO_W-1:0] q
);

  assign next_val = load ? d : q;

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= next_val;
  end

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(load)) |-> $stable(q)); // R1

  AST_LATCH_LOAD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(load)) |-> (q == $past(d))); // R1

endmodule

// File: rtl/bsd_cmd_decode.sv
module bsd_cmd_decode
  import bsd_pkg::*;
(
  input  logic     rd_n,
  input  logic     wr_n,
  input  logic     io_cyc,
  output bsd_cmd_t cmd,
  output logic     conflict
);

  logic rd_act, wr_act, single;

  always_comb begin
    rd_act   = ~rd_n;
    wr_act   = ~wr_n;
    conflict = rd_act & wr_act;
    single   = rd_act ^ wr_act;
    cmd.mem_rd = single & rd_act & ~io_cyc;
    cmd.mem_wr = single & wr_act & ~io_cyc;
    cmd.io_rd  = single & rd_act &  io_cyc;
    cmd.io_wr  = single & wr_act &  io_cyc;
  end

endmodule

// File: rtl/bsd_region_match.sv
module bsd_region_match #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned BASE   = 0,
  parameter int unsigned BYTES  = 16384
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);

  localparam logic [ADDR_W:0] LO_LIM = (ADDR_W+1)'(BASE);
  localparam logic [ADDR_W:0] HI_LIM = (ADDR_W+1)'(BASE + BYTES);

  logic [ADDR_W:0] ext;

  always_comb begin
    ext = {1'b0, addr};
    hit = (ext >= LO_LIM) && (ext < HI_LIM);
  end

endmodule

// File: rtl/bsd_port_decode.sv
module bsd_port_decode #(
  parameter int unsigned PORT_BITS = 3,
  localparam int unsigned N_PORTS = 1 << PORT_BITS
) (
  input  logic                 enable,
  input  logic [PORT_BITS-1:0] idx,
  output logic [N_PORTS-1:0]   sel
);

  for (genvar k = 0; k < N_PORTS; k++) begin : g_port
    assign sel[k] = enable && (idx == PORT_BITS'(k));
  end

endmodule

// File: rtl/bus_split_decoder.sv
module bus_split_decoder
  import bsd_pkg::*;
#(
  parameter int unsigned LO_W      = 8,
  parameter int unsigned HI_W      = 8,
  parameter int unsigned ROM_BASE  = 32'h0000,
  parameter int unsigned ROM_BYTES = 32'h4000,
  parameter int unsigned RAM_BASE  = 32'h4000,
  parameter int unsigned RAM_BYTES = 32'h2000,
  parameter int unsigned PORT_BITS = 3,
  localparam int unsigned ADDR_W  = LO_W + HI_W,
  localparam int unsigned N_PORTS = 1 << PORT_BITS
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               addr_strobe,
  input  logic [LO_W-1:0]    ad_lo,
  input  logic [HI_W-1:0]    a_hi,
  input  logic               rd_n,
  input  logic               wr_n,
  input  logic               io_not_mem,
  output logic [ADDR_W-1:0]  sys_addr,
  output logic               mem_rd_n,
  output logic               mem_wr_n,
  output logic               io_rd_n,
  output logic               io_wr_n,
  output logic               rom_sel_n,
  output logic               ram_sel_n,
  output logic [N_PORTS-1:0] port_sel_n,
  output logic               bus_err
);

  logic [LO_W-1:0]   lo_next, lo_q;
  logic [HI_W-1:0]   hi_q;
  logic [ADDR_W-1:0] addr_next;
  bsd_cmd_t          cmd;
  logic              conflict, mem_cyc, io_cyc;
  logic              rom_hit, ram_hit;
  logic [N_PORTS-1:0] port_hit;

  bsd_addr_latch #(.LO_W(LO_W)) u_lo (
    .clk(clk), .rst(rst), .load(addr_strobe), .d(ad_lo),
    .next_val(lo_next), .q(lo_q)
  );

  bsd_cmd_decode u_cmd (
    .rd_n(rd_n), .wr_n(wr_n), .io_cyc(io_not_mem),
    .cmd(cmd), .conflict(conflict)
  );

  assign addr_next = {a_hi, lo_next};
  assign mem_cyc   = cmd.mem_rd | cmd.mem_wr;
  assign io_cyc    = cmd.io_rd  | cmd.io_wr;

  bsd_region_match #(.ADDR_W(ADDR_W), .BASE(ROM_BASE), .BYTES(ROM_BYTES)) u_rom (
    .addr(addr_next), .hit(rom_hit)
  );

  bsd_region_match #(.ADDR_W(ADDR_W), .BASE(RAM_BASE), .BYTES(RAM_BYTES)) u_ram (
    .addr(addr_next), .hit(ram_hit)
  );

  bsd_port_decode #(.PORT_BITS(PORT_BITS)) u_port (
    .enable(io_cyc), .idx(a_hi[HI_W-1 -: PORT_BITS]), .sel(port_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q       <= '0;
      mem_rd_n   <= 1'b1;
      mem_wr_n   <= 1'b1;
      io_rd_n    <= 1'b1;
      io_wr_n    <= 1'b1;
      rom_sel_n  <= 1'b1;
      ram_sel_n  <= 1'b1;
      port_sel_n <= '1;
      bus_err    <= 1'b0;
    end else begin
      hi_q       <= a_hi;
      mem_rd_n   <= ~cmd.mem_rd;
      mem_wr_n   <= ~cmd.mem_wr;
      io_rd_n    <= ~cmd.io_rd;
      io_wr_n    <= ~cmd.io_wr;
      rom_sel_n  <= ~(mem_cyc & rom_hit);
      ram_sel_n  <= ~(mem_cyc & ram_hit);
      port_sel_n <= ~port_hit;
      bus_err    <= conflict;
    end
  end

  assign sys_addr = {hi_q, lo_q};

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $countones({~mem_rd_n, ~mem_wr_n, ~io_rd_n, ~io_wr_n}) <= 1); // R3

  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> (mem_rd_n && mem_wr_n && io_rd_n && io_wr_n && rom_sel_n
                 && ram_sel_n && (port_sel_n == '1))); // R4

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(rd_n) && $past(wr_n)) |->
      (mem_rd_n && mem_wr_n && io_rd_n && io_wr_n && rom_sel_n && ram_sel_n
       && (port_sel_n == '1))); // R5

  AST_MEM_SEL_MEMCYC: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (!rom_sel_n || !ram_sel_n)) |-> !$past(io_not_mem)); // R8

  AST_PORT_IOCYC: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (port_sel_n != '1)) |->
      ($past(io_not_mem) && $onehot0(~port_sel_n))); // R9

  AST_ONE_MEM_DEV: assert property (@(posedge clk) disable iff (rst)
    !(!rom_sel_n && !ram_sel_n)); // R11

endmodule

// File: tb/test_bus_split_decoder.sv
module test_bus_split_decoder;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       addr_strobe = 1'b0;
  logic [7:0] ad_lo = 8'h00;
  logic [7:0] a_hi = 8'h00;
  logic       rd_n = 1'b1;
  logic       wr_n = 1'b1;
  logic       io_not_mem = 1'b0;

  logic [15:0] sys_addr;
  logic mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, rom_sel_n, ram_sel_n, bus_err;
  logic [7:0] port_sel_n;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  bit model_on = 0;

  // reference model state
  int m_lo = 0, m_hi = 0;
  bit m_mrd = 1, m_mwr = 1, m_ird = 1, m_iwr = 1, m_rom = 1, m_ram = 1, m_err = 0;
  int m_port = 255;

  always #4 clk = ~clk;

  bus_split_decoder i_bus_split_decoder (
    .clk(clk), .rst(rst), .addr_strobe(addr_strobe), .ad_lo(ad_lo), .a_hi(a_hi),
    .rd_n(rd_n), .wr_n(wr_n), .io_not_mem(io_not_mem), .sys_addr(sys_addr),
    .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .io_rd_n(io_rd_n), .io_wr_n(io_wr_n),
    .rom_sel_n(rom_sel_n), .ram_sel_n(ram_sel_n), .port_sel_n(port_sel_n),
    .bus_err(bus_err)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference, evaluated at each rising edge
  always @(posedge clk) begin
    int a;
    bit rd, wr, one;
    model_on = 1;
    if (rst) begin
      m_lo = 0; m_hi = 0; m_mrd = 1; m_mwr = 1; m_ird = 1; m_iwr = 1;
      m_rom = 1; m_ram = 1; m_err = 0; m_port = 255;
    end else begin
      rd = !rd_n; wr = !wr_n; one = rd ^ wr;
      if (addr_strobe) m_lo = ad_lo;
      m_hi = a_hi;
      a = m_hi * 256 + m_lo;
      m_err = rd && wr;
      m_mrd = !(one && rd && !io_not_mem);
      m_mwr = !(one && wr && !io_not_mem);
      m_ird = !(one && rd && io_not_mem);
      m_iwr = !(one && wr && io_not_mem);
      m_rom = !(one && !io_not_mem && a < 16384);
      m_ram = !(one && !io_not_mem && a >= 16384 && a < 24576);
      m_port = (one && io_not_mem) ? (255 ^ (1 << (m_hi >> 5))) : 255;
    end
  end

  always @(posedge clk) begin
    #2;
    if (model_on && !finished) begin
      chk("R1 low addr", sys_addr[7:0], m_lo);
      chk("R2 high addr", sys_addr[15:8], m_hi);
      chk("R3 strobes", {mem_rd_n, mem_wr_n, io_rd_n, io_wr_n}, {m_mrd, m_mwr, m_ird, m_iwr});
      chk("R4 err", bus_err, m_err);
      chk("R6 rom sel", rom_sel_n, m_rom);
      chk("R7 ram sel", ram_sel_n, m_ram);
      chk("R9 port sel", port_sel_n, m_port);
      chk("R11 one mem dev", (!rom_sel_n && !ram_sel_n), 0);
    end
  end

  task automatic bus_cycle(input bit io, input logic [15:0] a, input bit wr);
    @(negedge clk);
    addr_strobe = 1; ad_lo = a[7:0]; a_hi = a[15:8]; io_not_mem = io;
    rd_n = 1; wr_n = 1;
    @(negedge clk);
    addr_strobe = 0; ad_lo = 8'hC3; rd_n = wr; wr_n = !wr;
    @(negedge clk);
  endtask

  task automatic release_bus();
    rd_n = 1; wr_n = 1;
    @(negedge clk);
  endtask

  initial begin
    // reset with busy inputs
    addr_strobe = 1; ad_lo = 8'h5A; a_hi = 8'h12; rd_n = 0; io_not_mem = 0;
    repeat (3) @(negedge clk);
    chk("R10 reset strobes", {mem_rd_n, mem_wr_n, io_rd_n, io_wr_n}, 4'hF);
    chk("R10 reset sels", {rom_sel_n, ram_sel_n, port_sel_n}, 10'h3FF);
    chk("R10 reset err/addr", {bus_err, sys_addr}, 0);
    rd_n = 1; addr_strobe = 0;
    @(negedge clk);
    rst = 0;
    repeat (2) @(negedge clk);
    chk("R5 idle", {mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, rom_sel_n, ram_sel_n, port_sel_n}, 14'h3FFF);
    chk("R1 held after reset", sys_addr[7:0], 0);

    bus_cycle(0, 16'h1234, 0);
    chk("R6 rom read", {rom_sel_n, ram_sel_n, mem_rd_n}, 3'b010);
    chk("R1 address", sys_addr, 16'h1234);
    release_bus();
    chk("R5 released", {mem_rd_n, rom_sel_n}, 2'b11);
    bus_cycle(0, 16'h3FFF, 1);
    chk("R6 rom top write", {rom_sel_n, ram_sel_n, mem_wr_n}, 3'b010);
    release_bus();
    bus_cycle(0, 16'h4000, 0);
    chk("R7 ram base", {rom_sel_n, ram_sel_n}, 2'b10);
    release_bus();
    bus_cycle(0, 16'h5FFF, 1);
    chk("R7 ram top", {rom_sel_n, ram_sel_n}, 2'b10);
    release_bus();
    bus_cycle(0, 16'h6000, 0);
    chk("R8 above ram", {rom_sel_n, ram_sel_n, mem_rd_n}, 3'b110);
    release_bus();
    bus_cycle(0, 16'hFFFF, 1);
    chk("R8 top of map", {rom_sel_n, ram_sel_n}, 2'b11);
    release_bus();
    bus_cycle(1, 16'hA055, 0);
    chk("R9 io read port5", port_sel_n, 8'hDF);
    chk("R8 io no mem sel", {rom_sel_n, ram_sel_n, io_rd_n}, 3'b110);
    release_bus();
    bus_cycle(1, 16'hE001, 1);
    chk("R9 io write port7", {port_sel_n, io_wr_n}, {8'h7F, 1'b0});
    release_bus();
    bus_cycle(0, 16'h0100, 0);
    wr_n = 0;
    @(negedge clk);
    chk("R4 conflict", {bus_err, mem_rd_n, mem_wr_n, rom_sel_n}, 4'b1111);
    release_bus();
    chk("R4 err clears", bus_err, 0);

    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      addr_strobe = ($urandom_range(0, 3) == 0);
      ad_lo = 8'($urandom);
      a_hi = 8'($urandom);
      rd_n = ($urandom_range(0, 2) != 0);
      wr_n = ($urandom_range(0, 2) != 0);
      io_not_mem = $urandom_range(0, 1) == 1;
    end
    release_bus();
    @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(8 * 100000);
    if (!finished) begin
      finished = 1;
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule